// File: doc/BRIEF.md
# JTAG Debug Port with Wishbone Memory Access

This block is a JTAG test access port that lets an external debugger reach system memory through a Wishbone bus master. The debugger drives the usual four scan pins plus an optional active-low asynchronous reset. Its sixteen-state TAP controller steers scans into a 4-bit instruction register or into one of several data registers. The data registers are an identification word, a one-bit bypass stage, a 30-bit word-address register, a read-only memory data register and a read-write memory data register.

The scan logic runs on TCK and the bus master runs on the system clock. Requests cross from the TCK side to the system side as a toggle with its fields held steady, and completion comes back the same way. The bus side prefetches the word at the current address. A data scan under a memory instruction therefore shifts out that word straight from Capture-DR. Each completed memory scan causes one bus access, and the word address then advances by one. A read-write scan writes the shifted-in word first and then prefetches the next word. A read scan only moves to the next address and prefetches it. Loading a new address also starts a prefetch.

Top module: `jtag_wb_port`

## Requirements
- R1: Test-Logic-Reset selects the identification instruction. The controller reaches it when trstN is low or after five TCK cycles with TMS high. While trstN is low, tdo is 0.
- R2: With the identification instruction, a 32-bit data scan shifts out 0x000018FF, least significant bit first. Every repeated scan gives the same value, whether sysRst is high or low.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, so an instruction scan shifts out 1,0,0,0. The new code takes effect at Update-IR.
- R4: Every code except 4'b0001, 4'b0101, 4'b0110 and 4'b0111 selects a 1-bit bypass stage, and this includes 4'b1111. The stage captures 0, so the first bit out is 0 and each later bit out is the bit shifted in one TCK earlier.
- R5: Code 4'b0101 selects a 30-bit word-address register. A scan shifts out the current address, and Update-DR loads the shifted-in value as the new address.
- R6: Under code 4'b0111, a 32-bit scan shifts out the word stored at the current address. At Update-DR that address is written with the shifted-in word, with wbWe high and wbSel all ones.
- R7: Under code 4'b0110, a 32-bit scan shifts out the word stored at the current address. The shifted-in bits are ignored and no bus write is issued.
- R8: Each completed data scan under code 4'b0110 or 4'b0111 adds one to the word address. For example, loading 1 and then doing two accesses makes the next address scan report 3.
- R9: wbCyc and wbStb go high together, and wbAdr and wbWe stay constant until the cycle in which wbAck is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock |
| trstN | input | 1 | Asynchronous scan-side reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| sysClk | input | 1 | System clock for the bus master |
| sysRst | input | 1 | Synchronous system reset, active high |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Write enable |
| wbSel | output | 4 | Byte selects |
| wbAdr | output | 30 | Word address |
| wbDatW | output | 32 | Write data |
| wbDatR | input | 32 | Read data |
| wbAck | input | 1 | Bus acknowledge |

## Verification
The bench loads address 1, writes two words, reloads address 1 and then reads the words back. A design that captured the address after the increment, or that forgot to increment, would report something other than 3 on the reload. A design that lost the prefetch would shift out stale data. During read-only scans the bench shifts in all ones while it counts bus writes, which exposes a design that writes during a read. The bench also checks that bypass delays data by exactly one stage under both an unused code and the all-ones code. It checks that the identification word comes back while the system is still in reset, and again after a TMS-only reset.

// File: rtl/jtagwb_pkg.sv
package jtagwb_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] IR_MADDR   = 4'b0101;
  localparam logic [IR_W-1:0] IR_MREAD   = 4'b0110;
  localparam logic [IR_W-1:0] IR_MRDWR   = 4'b0111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE, TAP_SELDR, TAP_CAPDR, TAP_SHDR, TAP_EX1DR,
    TAP_PAUSEDR, TAP_EX2DR, TAP_UPDDR, TAP_SELIR, TAP_CAPIR, TAP_SHIR,
    TAP_EX1IR, TAP_PAUSEIR, TAP_EX2IR, TAP_UPDIR
  } tapState_e;

  typedef enum logic [2:0] {DR_BYPASS, DR_IDCODE, DR_ADDR, DR_READ, DR_RDWR} drSel_e;

  typedef struct packed {
    logic   capture;
    logic   shift;
    logic   update;
    drSel_e sel;
  } drStrobe_t;

  typedef enum logic [1:0] {BUS_IDLE, BUS_WRITE, BUS_READ} busState_e;
endpackage

// File: rtl/jtagwb_ctrl.sv
module jtagwb_ctrl
  import jtagwb_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  input  logic      tdi,
  input  logic      drTdo,
  output drStrobe_t strobe,
  output logic      tdo
);
  tapState_e state, nextState;
  logic [IR_W-1:0] irShift, irCur;

  always_comb begin
    case (state)
      TAP_RESET:   nextState = tms ? TAP_RESET   : TAP_IDLE;
      TAP_IDLE:    nextState = tms ? TAP_SELDR   : TAP_IDLE;
      TAP_SELDR:   nextState = tms ? TAP_SELIR   : TAP_CAPDR;
      TAP_CAPDR:   nextState = tms ? TAP_EX1DR   : TAP_SHDR;
      TAP_SHDR:    nextState = tms ? TAP_EX1DR   : TAP_SHDR;
      TAP_EX1DR:   nextState = tms ? TAP_UPDDR   : TAP_PAUSEDR;
      TAP_PAUSEDR: nextState = tms ? TAP_EX2DR   : TAP_PAUSEDR;
      TAP_EX2DR:   nextState = tms ? TAP_UPDDR   : TAP_SHDR;
      TAP_UPDDR:   nextState = tms ? TAP_SELDR   : TAP_IDLE;
      TAP_SELIR:   nextState = tms ? TAP_RESET   : TAP_CAPIR;
      TAP_CAPIR:   nextState = tms ? TAP_EX1IR   : TAP_SHIR;
      TAP_SHIR:    nextState = tms ? TAP_EX1IR   : TAP_SHIR;
      TAP_EX1IR:   nextState = tms ? TAP_UPDIR   : TAP_PAUSEIR;
      TAP_PAUSEIR: nextState = tms ? TAP_EX2IR   : TAP_PAUSEIR;
      TAP_EX2IR:   nextState = tms ? TAP_UPDIR   : TAP_SHIR;
      TAP_UPDIR:   nextState = tms ? TAP_SELDR   : TAP_IDLE;
      default:     nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TAP_RESET;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irCur   <= IR_IDCODE;
    end else begin
      case (state)
        TAP_RESET: irCur   <= IR_IDCODE;
        TAP_CAPIR: irShift <= IR_CAPTURE;
        TAP_SHIR:  irShift <= {tdi, irShift[IR_W-1:1]};
        TAP_UPDIR: irCur   <= irShift;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (irCur)
      IR_IDCODE: strobe.sel = DR_IDCODE;
      IR_MADDR:  strobe.sel = DR_ADDR;
      IR_MREAD:  strobe.sel = DR_READ;
      IR_MRDWR:  strobe.sel = DR_RDWR;
      default:   strobe.sel = DR_BYPASS;
    endcase
    strobe.capture = (state == TAP_CAPDR);
    strobe.shift   = (state == TAP_SHDR);
    strobe.update  = (state == TAP_UPDDR);
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                 tdo <= 1'b0;
    else if (state == TAP_SHIR) tdo <= irShift[0];
    else if (state == TAP_SHDR) tdo <= drTdo;
    else                        tdo <= 1'b0;
  end

  // R1
  reset_ir_chk: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_RESET) |=> (irCur == IR_IDCODE));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_CAPIR) |=> (irShift == IR_CAPTURE));
endmodule

// File: rtl/jtagwb_dp.sv
module jtagwb_dp
  import jtagwb_pkg::*;
#(
  parameter int          ADDR_W     = 30,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h000018FF
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  drStrobe_t         strobe,
  input  logic [DATA_W-1:0] fetchData,
  input  logic              ackToggle,
  output logic              drTdo,
  output logic              reqToggle,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqWrAddr,
  output logic [ADDR_W-1:0] reqRdAddr,
  output logic [DATA_W-1:0] reqWrData
);
  localparam int SR_W = (DATA_W > 32) ? DATA_W : 32;

  logic [SR_W-1:0]   sr, srShifted, capVal;
  logic [ADDR_W-1:0] addr, addrNext;
  logic              ackMeta, ackSync, busy;
  int                shLen;

  assign busy     = reqToggle ^ ackSync;
  assign addrNext = addr + 1'b1;
  assign drTdo    = sr[0];

  always_comb begin
    case (strobe.sel)
      DR_BYPASS: begin shLen = 1;      capVal = '0;                end
      DR_IDCODE: begin shLen = 32;     capVal = SR_W'(IDCODE_VAL); end
      DR_ADDR:   begin shLen = ADDR_W; capVal = SR_W'(addr);       end
      default:   begin shLen = DATA_W; capVal = SR_W'(fetchData);  end
    endcase
  end

  always_comb begin
    for (int i = 0; i < SR_W; i++) begin
      if (i == shLen - 1)     srShifted[i] = tdi;
      else if (i < shLen - 1) srShifted[i] = sr[(i + 1) % SR_W];
      else                    srShifted[i] = 1'b0;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      ackMeta <= 1'b0;
      ackSync <= 1'b0;
    end else begin
      ackMeta <= ackToggle;
      ackSync <= ackMeta;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      sr        <= '0;
      addr      <= '0;
      reqToggle <= 1'b0;
      reqWrite  <= 1'b0;
      reqWrAddr <= '0;
      reqRdAddr <= '0;
      reqWrData <= '0;
    end else begin
      if (strobe.capture)    sr <= capVal;
      else if (strobe.shift) sr <= srShifted;
      if (strobe.update && !busy) begin
        case (strobe.sel)
          DR_ADDR: begin
            addr      <= sr[ADDR_W-1:0];
            reqRdAddr <= sr[ADDR_W-1:0];
            reqWrite  <= 1'b0;
            reqToggle <= ~reqToggle;
          end
          DR_READ: begin
            addr      <= addrNext;
            reqRdAddr <= addrNext;
            reqWrite  <= 1'b0;
            reqToggle <= ~reqToggle;
          end
          DR_RDWR: begin
            addr      <= addrNext;
            reqRdAddr <= addrNext;
            reqWrAddr <= addr;
            reqWrData <= sr[DATA_W-1:0];
            reqWrite  <= 1'b1;
            reqToggle <= ~reqToggle;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  addr_load_chk: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.update && !busy && strobe.sel == DR_ADDR) |=> (addr == $past(sr[ADDR_W-1:0])));

  // R8
  addr_step_chk: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.update && !busy && (strobe.sel == DR_READ || strobe.sel == DR_RDWR))
      |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R7
  read_nowrite_chk: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.update && !busy && strobe.sel == DR_READ) |=> !reqWrite);
endmodule

// File: rtl/jtagwb_bus.sv
module jtagwb_bus
  import jtagwb_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic                sysClk,
  input  logic                sysRst,
  input  logic                reqToggle,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqWrAddr,
  input  logic [ADDR_W-1:0]   reqRdAddr,
  input  logic [DATA_W-1:0]   reqWrData,
  output logic [DATA_W-1:0]   fetchData,
  output logic                ackToggle,
  output logic                wbCyc,
  output logic                wbStb,
  output logic                wbWe,
  output logic [DATA_W/8-1:0] wbSel,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [DATA_W-1:0]   wbDatW,
  input  logic [DATA_W-1:0]   wbDatR,
  input  logic                wbAck
);
  localparam int SEL_W = DATA_W / 8;

  busState_e state;
  logic      reqMeta, reqSync, reqSeen;

  assign wbCyc = (state != BUS_IDLE);
  assign wbStb = wbCyc;
  assign wbSel = {SEL_W{wbCyc}};

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      state     <= BUS_IDLE;
      reqMeta   <= 1'b0;
      reqSync   <= 1'b0;
      reqSeen   <= 1'b0;
      ackToggle <= 1'b0;
      fetchData <= '0;
      wbWe      <= 1'b0;
      wbAdr     <= '0;
      wbDatW    <= '0;
    end else begin
      reqMeta <= reqToggle;
      reqSync <= reqMeta;
      case (state)
        BUS_IDLE: if (reqSync != reqSeen) begin
          reqSeen <= reqSync;
          if (reqWrite) begin
            state  <= BUS_WRITE;
            wbAdr  <= reqWrAddr;
            wbDatW <= reqWrData;
            wbWe   <= 1'b1;
          end else begin
            state <= BUS_READ;
            wbAdr <= reqRdAddr;
            wbWe  <= 1'b0;
          end
        end
        BUS_WRITE: if (wbAck) begin
          state <= BUS_READ;
          wbAdr <= reqRdAddr;
          wbWe  <= 1'b0;
        end
        BUS_READ: if (wbAck) begin
          fetchData <= wbDatR;
          ackToggle <= reqSeen;
          state     <= BUS_IDLE;
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  // R9
  stb_hold_chk: assert property (@(posedge sysClk) disable iff (sysRst)
    (wbStb && !wbAck) |=> (wbStb && wbCyc && $stable(wbAdr) && $stable(wbWe)));

  // R6
  wr_then_rd_chk: assert property (@(posedge sysClk) disable iff (sysRst)
    (state == BUS_WRITE && wbAck) |=> (wbCyc && !wbWe));
endmodule

// File: rtl/jtag_wb_port.sv
module jtag_wb_port
  import jtagwb_pkg::*;
#(
  parameter int          ADDR_W     = 30,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h000018FF
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  input  logic                sysClk,
  input  logic                sysRst,
  output logic                wbCyc,
  output logic                wbStb,
  output logic                wbWe,
  output logic [DATA_W/8-1:0] wbSel,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [DATA_W-1:0]   wbDatW,
  input  logic [DATA_W-1:0]   wbDatR,
  input  logic                wbAck
);
  drStrobe_t         strobe;
  logic              drTdo, reqToggle, reqWrite, ackToggle;
  logic [ADDR_W-1:0] reqWrAddr, reqRdAddr;
  logic [DATA_W-1:0] reqWrData, fetchData;

  jtagwb_ctrl uCtrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .drTdo(drTdo), .strobe(strobe), .tdo(tdo)
  );

  jtagwb_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDCODE_VAL(IDCODE_VAL)) uDp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobe(strobe),
    .fetchData(fetchData), .ackToggle(ackToggle), .drTdo(drTdo),
    .reqToggle(reqToggle), .reqWrite(reqWrite), .reqWrAddr(reqWrAddr),
    .reqRdAddr(reqRdAddr), .reqWrData(reqWrData)
  );

  jtagwb_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uBus (
    .sysClk(sysClk), .sysRst(sysRst), .reqToggle(reqToggle), .reqWrite(reqWrite),
    .reqWrAddr(reqWrAddr), .reqRdAddr(reqRdAddr), .reqWrData(reqWrData),
    .fetchData(fetchData), .ackToggle(ackToggle), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .wbSel(wbSel), .wbAdr(wbAdr), .wbDatW(wbDatW),
    .wbDatR(wbDatR), .wbAck(wbAck)
  );
endmodule

// File: tb/sim_jtag_wb_port.sv
`timescale 1ns/1ps
module sim_jtag_wb_port;
  localparam logic [31:0] ID_EXP = 32'h000018FF;

  logic        tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic        sysClk = 1'b0, sysRst = 1'b1;
  logic        tdo, wbCyc, wbStb, wbWe, wbAck;
  logic [3:0]  wbSel;
  logic [29:0] wbAdr;
  logic [31:0] wbDatW, wbDatR;
  logic [31:0] mem [0:15];
  int          checks = 0, failures = 0, writeCount = 0, selBad = 0, sysCycles = 0;

  jtag_wb_port u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .sysClk(sysClk), .sysRst(sysRst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbSel(wbSel), .wbAdr(wbAdr), .wbDatW(wbDatW), .wbDatR(wbDatR), .wbAck(wbAck)
  );

  always #2.5 sysClk = ~sysClk;

  // Bus slave model: registered ack, 16-word memory
  always @(posedge sysClk) begin
    sysCycles++;
    if (sysRst) begin
      wbAck  <= 1'b0;
      wbDatR <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE0000 + i;
    end else begin
      wbAck <= wbCyc && wbStb && !wbAck;
      if (wbCyc && wbStb && !wbAck) begin
        if (wbWe) begin
          mem[wbAdr[3:0]] <= wbDatW;
          writeCount++;
          if (wbSel != 4'hF) selBad++;
        end
        wbDatR <= mem[wbAdr[3:0]];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tckCycle(input logic tmsV, input logic tdiV, output logic tdoV);
    tms = tmsV; tdi = tdiV;
    #25 tdoV = tdo;
    #25 tck = 1'b1;
    #50 tck = 1'b0;
  endtask

  task automatic idle(input int n);
    logic d;
    for (int i = 0; i < n; i++) tckCycle(1'b0, 1'b0, d);
  endtask

  task automatic scanIr(input logic [3:0] code, output logic [3:0] capt);
    logic d;
    tckCycle(1, 0, d); tckCycle(1, 0, d); tckCycle(0, 0, d); tckCycle(0, 0, d);
    for (int i = 0; i < 4; i++) tckCycle(i == 3, code[i], capt[i]);
    tckCycle(1, 0, d); tckCycle(0, 0, d);
    idle(2);
  endtask

  task automatic scanDr(input int len, input logic [31:0] din, output logic [31:0] dout);
    logic d;
    dout = '0;
    tckCycle(1, 0, d); tckCycle(0, 0, d); tckCycle(0, 0, d);
    for (int i = 0; i < len; i++) tckCycle(i == len - 1, din[i], dout[i]);
    tckCycle(1, 0, d); tckCycle(0, 0, d);
    idle(4);
  endtask

  task automatic testResetState();
    logic [31:0] v1, v2;
    #20 check("R1 tdo low in trst", {31'd0, tdo}, 32'd0);
    #100 trstN = 1'b1;
    idle(2);
    scanDr(32, 32'h0, v1);
    check("R1 IDCODE after trst (sys in reset)", v1, ID_EXP);
    scanDr(32, 32'hFFFFFFFF, v2);
    check("R2 repeated IDCODE (sys in reset)", v2, v1);
  endtask

  task automatic testIrAndBypass();
    logic [3:0]  capt;
    logic [31:0] v;
    scanIr(4'b1111, capt);
    check("R3 capture-IR value", {28'd0, capt}, 32'h1);
    scanDr(8, 32'hB6, v);
    check("R4 bypass on all-ones code", v, 32'h6C);
    scanIr(4'b0011, capt);
    scanDr(8, 32'h53, v);
    check("R4 bypass on unused code", v, 32'hA6);
  endtask

  task automatic testTmsReset();
    logic [31:0] v;
    logic        d;
    for (int i = 0; i < 5; i++) tckCycle(1, 0, d);
    idle(2);
    scanDr(32, 32'h0, v);
    check("R1 IDCODE after five TMS high", v, ID_EXP);
  endtask

  task automatic testIdRunning();
    logic [31:0] v;
    sysRst = 1'b0;
    idle(3);
    scanDr(32, 32'h0, v);
    check("R2 IDCODE with system running", v, ID_EXP);
  endtask

  task automatic testFirstWrites();
    logic [3:0]  capt;
    logic [31:0] v;
    scanIr(4'b0101, capt);
    scanDr(30, 32'h1, v);
    check("R5 initial address shifted out", v, 32'h0);
    scanIr(4'b0111, capt);
    scanDr(32, 32'h55555555, v);
    check("R6 rdwr returns old word at 1", v, 32'hC0DE0001);
    scanDr(32, 32'hAAAAAAAA, v);
    check("R8 rdwr second access at address 2", v, 32'hC0DE0002);
    check("R6 word 1 written", mem[1], 32'h55555555);
    check("R6 word 2 written", mem[2], 32'hAAAAAAAA);
    check("R6 byte selects all ones on writes", selBad, 32'd0);
  endtask

  task automatic testRdwrSwap();
    logic [3:0]  capt;
    logic [31:0] v;
    scanIr(4'b0101, capt);
    scanDr(30, 32'h1, v);
    check("R8 address after two accesses", v, 32'h3);
    scanIr(4'b0111, capt);
    scanDr(32, 32'hAAAAAAAA, v);
    check("R6 rdwr swap word 1", v, 32'h55555555);
    scanDr(32, 32'h55555555, v);
    check("R6 rdwr swap word 2", v, 32'hAAAAAAAA);
  endtask

  task automatic testReadOnly();
    logic [3:0]  capt;
    logic [31:0] v;
    int          wrBefore;
    scanIr(4'b0101, capt);
    scanDr(30, 32'h1, v);
    check("R5 address register shows 3", v, 32'h3);
    wrBefore = writeCount;
    scanIr(4'b0110, capt);
    scanDr(32, 32'hFFFFFFFF, v);
    check("R7 read word 1", v, 32'hAAAAAAAA);
    scanDr(32, 32'hFFFFFFFF, v);
    check("R7 read word 2", v, 32'h55555555);
    check("R7 no bus write during reads", writeCount - wrBefore, 32'd0);
    scanIr(4'b0101, capt);
    scanDr(30, 32'h1, v);
    check("R8 read scans advance address", v, 32'h3);
    scanIr(4'b0110, capt);
    scanDr(32, 32'h0, v);
    check("R7 word 1 unchanged by read", v, 32'hAAAAAAAA);
    check("R9 byte selects stayed all ones", selBad, 32'd0);
  endtask

  initial begin
    testResetState();
    testIrAndBypass();
    testTmsReset();
    testIdRunning();
    testFirstWrites();
    testRdwrSwap();
    testReadOnly();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (sysCycles > 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule